// File: doc/BRIEF.md
# SPI Serial Nonvolatile Memory Command Controller

This block is the slave side of a byte-wide serial memory on an SPI bus, in clock modes 0 and 3. A host selects it with an active-low select, clocks in an 8-bit opcode and, for array access, a 16-bit address. It then streams data in or out, most significant bit first. Array writes go into a one-page staging buffer. The buffer is committed only when the select line rises at a byte boundary. A self-timed write cycle then copies it into the array while a busy flag is shown in the status byte. Status writes follow the same commit rule. They update two region-protect bits and a pin-lock enable bit.

All serial pins are sampled by the system clock through synchronizers. Edges of the select and serial clock are detected in that domain, so the system clock must run several times faster than the serial clock. The data output is split into a value and an output enable, so a pad cell outside the block can make it high impedance. Serial traffic has no back-pressure: the host owns the serial clock, so the data stream uses no valid/ready handshake. Every pin is plain control or data.

Top module: `spi_nvm_ctrl`

## Requirements
- R1: Opcodes are 0x06 (set write latch), 0x04 (clear write latch), 0x05 (read status), 0x01 (write status), 0x03 (read array) and 0x02 (write array). All bytes travel MSB first; any other opcode makes the rest of the frame ignored.
- R2: Input bits are taken on rising serial-clock edges and the output bit changes only on falling edges; `so_en` is low whenever the select is high.
- R3: After a read or write opcode come two address bytes, high byte first; only the low ADDR_W bits select a byte (default 11, a 2 KiB array).
- R4: A read streams consecutive bytes for as long as clocks continue, with the address wrapping from the top of the array to 0.
- R5: A write carries 1 to 32 data bytes; the low 5 address bits wrap inside the page, so bytes past the page end overwrite earlier ones.
- R6: An array or status write commits only if the select rises right after the last bit of a complete data byte; at any other point nothing changes and no write cycle starts.
- R7: The write-latch set and clear commands act only if the select rises right after their eighth bit; one extra clock cancels them.
- R8: After reset, all traffic is ignored until a falling edge of the select is seen.
- R9: Holding `hold_n` low while the serial clock is low disables the output and freezes the transfer; serial-clock edges during the hold are ignored, and release resumes at the same bit.
- R10: A committed write starts a cycle of WRITE_CLKS system clocks. During it the status byte reads 0xFF. Afterwards the status byte has bit 0 (busy) clear and bit 1 (write latch) clear.
- R11: While busy, every opcode except status read is ignored and no array byte or status bit changes.
- R12: Status bits [3:2] protect the array: 1 = top quarter, 2 = top half, 3 = all. An array write to a protected page is discarded, the write latch stays set and no cycle starts. Writes also need the latch set.
- R13: A status write stores bits 7, 3 and 2 and reads other bits as 0. When bit 7 is set and `wp_n` is low, status writes are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause |
| wp_n | input | 1 | Active-low status write lock |
| so | output | 1 | Serial data out value |
| so_en | output | 1 | Output enable for the data out pad |

## Verification
On every cycle, the assertions check four things. The output bit changes only on a falling serial edge or at frame start. A paused transfer keeps its bit position. The write latch never rises during a busy cycle and is cleared when the cycle ends. The protect and lock bits stay frozen while busy. Only the bench scenarios can show end-to-end effects. These include commit-versus-discard at the select edge, page and array wrap-around, block protection and the pin lock, and the data read back after a pause.

// File: rtl/spi_nvm_pkg.sv
package spi_nvm_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  // frame phases of the serial protocol
  typedef enum logic [2:0] {
    PH_IDLE, PH_OPC, PH_ADDR, PH_WIN, PH_ROUT, PH_TAIL, PH_SKIP
  } phase_e;
endpackage

// File: rtl/spi_nvm_sync.sv
module spi_nvm_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din[i]};
    end
    assign lvl[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_nvm_wtimer.sv
module spi_nvm_wtimer #(
  parameter int WRITE_CLKS = 5000,
  parameter int PAGE_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [PAGE_W-1:0] idx,
  output logic              idx_ok
);
  localparam int CW      = $clog2(WRITE_CLKS + 1);
  localparam int PAGE_SZ = 1 << PAGE_W;

  logic [CW-1:0] cnt;

  assign done   = busy && (cnt == CW'(WRITE_CLKS - 1));
  assign idx    = cnt[PAGE_W-1:0];
  assign idx_ok = busy && (cnt < CW'(PAGE_SZ));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      cnt  <= cnt + 1'b1;
      if (done) busy <= 1'b0;
    end
  end

  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/spi_nvm_store.sv
module spi_nvm_store #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     buf_we,
  input  logic [PAGE_W-1:0]        buf_idx,
  input  logic [7:0]               buf_data,
  input  logic                     buf_clr,
  input  logic                     drain_en,
  input  logic                     drain_ok,
  input  logic [PAGE_W-1:0]        drain_idx,
  input  logic [ADDR_W-PAGE_W-1:0] page,
  input  logic [ADDR_W-1:0]        raddr,
  output logic [7:0]               rdata
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int PAGE_SZ = 1 << PAGE_W;

  logic [7:0]         mem  [DEPTH];
  logic [7:0]         pbuf [PAGE_SZ];
  logic [PAGE_SZ-1:0] vld;

  assign rdata = mem[raddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else if (buf_clr) vld <= '0;
    else if (buf_we) vld[buf_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_idx] <= buf_data;
  end

  // one staged byte per system clock during the opening slots of the cycle
  always_ff @(posedge clk) begin
    if (drain_en && drain_ok && vld[drain_idx])
      mem[{page, drain_idx}] <= pbuf[drain_idx];
  end
endmodule

// File: rtl/spi_nvm_ctrl.sv
module spi_nvm_ctrl
  import spi_nvm_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int PAGE_W     = 5,
  parameter int WRITE_CLKS = 5000,
  parameter int SYNC_N     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_en
);
  localparam int PG_W = ADDR_W - PAGE_W;
  localparam int HI_W = ADDR_W - 8;

  logic [4:0] pins_s;
  logic cs_s, sck_s, si_s, hold_s, wp_s, cs_d, sck_d;
  logic cs_fall, cs_rise, act_rise, act_fall;

  spi_nvm_sync #(.W(5), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({wp_n, hold_n, si, sck, cs_n}), .lvl(pins_s)
  );
  assign {wp_s, hold_s, si_s, sck_s, cs_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin cs_d <= 1'b0; sck_d <= 1'b0; end
    else        begin cs_d <= cs_s; sck_d <= sck_s; end
  end

  phase_e            phase;
  logic [7:0]        cmd, tx, sview, byte_in, rdata;
  logic [2:0]        bcnt;
  logic [6:0]        rx;
  logic [HI_W-1:0]   ahi;
  logic              ahi_done, commit_ok, armed, so_q, wel, wpen, sr_pend, arr_q;
  logic [1:0]        bp;
  logic [2:0]        sr_new;
  logic [ADDR_W-1:0] cur, raddr;
  logic [PG_W-1:0]   page;
  logic              wip, done, idx_ok, start, prot, hw_lock, byte_done, buf_we;
  logic [PAGE_W-1:0] didx;
  logic [1:0]        top2;

  assign cs_fall   = cs_d & ~cs_s;
  assign cs_rise   = ~cs_d & cs_s;
  assign act_rise  = sck_s & ~sck_d & hold_s & ~cs_s & armed & (phase != PH_IDLE);
  assign act_fall  = ~sck_s & sck_d & hold_s & ~cs_s & armed & (phase != PH_IDLE);
  assign byte_in   = {rx, si_s};
  assign byte_done = act_rise && (bcnt == 3'd7);
  assign raddr     = (phase == PH_ADDR) ? {ahi, byte_in} : cur;
  assign sview     = wip ? 8'hFF : {wpen, 3'b000, bp, wel, 1'b0};
  assign hw_lock   = wpen & ~wp_s;
  assign top2      = cur[ADDR_W-1 -: 2];
  assign prot      = (bp == 2'd3) || (bp == 2'd2 && top2[1]) || (bp == 2'd1 && top2 == 2'd3);
  assign start     = cs_rise && armed && commit_ok && wel && !wip && (phase == PH_WIN) &&
                     (((cmd == OP_WRSR) && !hw_lock) || ((cmd == OP_WRITE) && !prot));
  assign buf_we    = byte_done && (phase == PH_WIN) && (cmd == OP_WRITE);
  assign so        = so_q;
  assign so_en     = ~cs_s & hold_s & armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; cmd <= '0; tx <= '0; bcnt <= '0; rx <= '0; ahi <= '0;
      ahi_done <= 1'b0; commit_ok <= 1'b0; armed <= 1'b0; so_q <= 1'b0;
      wel <= 1'b0; wpen <= 1'b0; bp <= '0; sr_new <= '0; sr_pend <= 1'b0;
      arr_q <= 1'b0; cur <= '0; page <= '0;
    end else begin
      if (cs_fall) begin
        armed <= 1'b1; phase <= PH_OPC; bcnt <= '0; commit_ok <= 1'b0;
        so_q <= 1'b0; ahi_done <= 1'b0;
      end else if (cs_rise) begin
        phase <= PH_IDLE; commit_ok <= 1'b0;
        if (armed && commit_ok && phase == PH_TAIL && !wip) wel <= (cmd == OP_WREN);
        if (start) begin
          page <= cur[ADDR_W-1:PAGE_W]; sr_pend <= (cmd == OP_WRSR); arr_q <= (cmd == OP_WRITE);
        end
      end else begin
        if (act_rise) begin
          rx <= byte_in[6:0]; bcnt <= bcnt + 1'b1; commit_ok <= 1'b0;
          if (phase == PH_TAIL) phase <= PH_SKIP;
          if (bcnt == 3'd7) begin
            case (phase)
              PH_OPC: begin
                cmd <= byte_in;
                if (wip && byte_in != OP_RDSR) phase <= PH_SKIP;
                else case (byte_in)
                  OP_WREN, OP_WRDI: begin phase <= PH_TAIL; commit_ok <= 1'b1; end
                  OP_RDSR:          begin phase <= PH_ROUT; tx <= sview; end
                  OP_WRSR:          phase <= PH_WIN;
                  OP_READ, OP_WRITE: phase <= PH_ADDR;
                  default:          phase <= PH_SKIP;
                endcase
              end
              PH_ADDR: begin
                if (!ahi_done) begin
                  ahi <= byte_in[HI_W-1:0]; ahi_done <= 1'b1;
                end else if (cmd == OP_READ) begin
                  tx <= rdata; cur <= raddr + 1'b1; phase <= PH_ROUT;
                end else begin
                  cur <= raddr; phase <= PH_WIN;
                end
              end
              PH_WIN: begin
                commit_ok <= 1'b1;
                if (cmd == OP_WRSR) sr_new <= {byte_in[7], byte_in[3:2]};
                else cur[PAGE_W-1:0] <= cur[PAGE_W-1:0] + 1'b1;
              end
              PH_ROUT: begin
                if (cmd == OP_RDSR) tx <= sview;
                else begin tx <= rdata; cur <= cur + 1'b1; end
              end
              default: ;
            endcase
          end
        end
        if (act_fall && phase == PH_ROUT) begin
          so_q <= tx[7]; tx <= {tx[6:0], 1'b0};
        end
      end
      if (done) begin
        wel <= 1'b0;
        if (sr_pend) {wpen, bp} <= sr_new;
      end
    end
  end

  spi_nvm_wtimer #(.WRITE_CLKS(WRITE_CLKS), .PAGE_W(PAGE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(wip), .done(done),
    .idx(didx), .idx_ok(idx_ok)
  );

  spi_nvm_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_idx(cur[PAGE_W-1:0]),
    .buf_data(byte_in), .buf_clr(cs_fall && !wip), .drain_en(wip && arr_q),
    .drain_ok(idx_ok), .drain_idx(didx), .page(page), .raddr(raddr), .rdata(rdata)
  );

  // R2
  so_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(act_fall && phase == PH_ROUT) && !cs_fall) |=> $stable(so_q));
  // R9
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_s && !cs_fall && !cs_rise) |=> $stable(bcnt));
  // R10
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !wel);
  // R11
  wel_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wip |=> !$rose(wel));
  // R11
  sr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && !done) |=> $stable({wpen, bp}));
endmodule

// File: tb/test_spi_nvm_ctrl.sv
module test_spi_nvm_ctrl;
  localparam int WCLK = 2000;
  localparam int H    = 6;
  // {mode3, address, data}
  localparam logic [24:0] VEC [6] = '{
    {1'b0, 16'h0000, 8'hA5}, {1'b1, 16'h07FF, 8'h3C}, {1'b0, 16'h8123, 8'h5A},
    {1'b1, 16'h0456, 8'hC3}, {1'b0, 16'hF7FE, 8'h96}, {1'b0, 16'h0200, 8'h01}
  };

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b0, sck = 1'b0, si = 1'b0;
  logic hold_n = 1'b1, wp_n = 1'b1, m3 = 1'b0;
  logic so, so_en;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  spi_nvm_ctrl #(.WRITE_CLKS(WCLK)) i_spi_nvm_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_en(so_en)
  );

  task automatic tk(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bitx(input logic b, output logic o);
    sck = 1'b0; si = b; tk(H); o = so; sck = 1'b1; tk(H);
  endtask

  task automatic xbyte(input logic [7:0] d, output logic [7:0] q);
    for (int i = 7; i >= 0; i--) bitx(d[i], q[i]);
  endtask

  task automatic open_f(); sck = m3; tk(H); cs_n = 1'b0; tk(H); endtask
  task automatic close_f();
    if (!m3) begin sck = 1'b0; tk(H); end
    cs_n = 1'b1; tk(3*H);
  endtask

  task automatic op(input logic [7:0] c);
    logic [7:0] d; open_f(); xbyte(c, d); close_f();
  endtask

  task automatic rdsr(output logic [7:0] q);
    logic [7:0] d; open_f(); xbyte(8'h05, d); xbyte(8'h00, q); close_f();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d; op(8'h06); open_f(); xbyte(8'h01, d); xbyte(v, d); close_f(); tk(WCLK+100);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] v);
    logic [7:0] d;
    op(8'h06); open_f(); xbyte(8'h02, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
    xbyte(v, d); close_f(); tk(WCLK+100);
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] q);
    logic [7:0] d;
    open_f(); xbyte(8'h03, d); xbyte(a[15:8], d); xbyte(a[7:0], d); xbyte(8'h00, q); close_f();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] q, d;
    tk(5); rst_n = 1'b1; tk(5);
    // R8: select already low out of reset, no falling edge: WREN ignored
    xbyte(8'h06, d); sck = 1'b0; tk(H); cs_n = 1'b1; tk(3*H);
    chk("R2 so_en with select high", {7'b0, so_en}, 8'h00);
    rdsr(q); chk("R8 traffic before select edge ignored", q, 8'h00);

    // R1: table of writes and read-backs, both clock modes
    for (int i = 0; i < 6; i++) begin
      m3 = VEC[i][24];
      wr(VEC[i][23:8], VEC[i][7:0]);
      rd(VEC[i][23:8], q);
      chk("R1 write/read vector", q, VEC[i][7:0]);
    end
    m3 = 1'b0;

    // R3: upper address bits ignored
    rd(16'h0123, q); chk("R3 alias of 0x8123", q, 8'h5A);

    // R4: sequential read wraps from top to 0
    open_f(); xbyte(8'h03, d); xbyte(8'h07, d); xbyte(8'hFE, d);
    xbyte(8'h00, q); chk("R4 stream byte 0x7FE", q, 8'h96);
    xbyte(8'h00, q); chk("R4 stream byte 0x7FF", q, 8'h3C);
    xbyte(8'h00, q); chk("R4 stream wrap to 0", q, 8'hA5);
    close_f();

    // R5: 34 bytes from page offset 30 wrap inside the page
    op(8'h06); open_f(); xbyte(8'h02, d); xbyte(8'h01, d); xbyte(8'h1E, d);
    for (int i = 0; i < 34; i++) xbyte(8'h20 + 8'(i), d);
    close_f(); tk(WCLK+100);
    rd(16'h011E, q); chk("R5 offset 30 overwritten", q, 8'h40);
    rd(16'h011F, q); chk("R5 offset 31 overwritten", q, 8'h41);
    rd(16'h0100, q); chk("R5 offset 0 after wrap", q, 8'h22);
    rd(16'h011D, q); chk("R5 offset 29", q, 8'h3F);

    // R6: select rises mid-byte, then one bit past a byte
    op(8'h06); open_f(); xbyte(8'h02, d); xbyte(8'h00, d); xbyte(8'h00, d);
    for (int i = 0; i < 5; i++) bitx(1'b1, d[0]);
    close_f();
    rdsr(q); chk("R6 mid-byte rise starts no cycle", q, 8'h02);
    open_f(); xbyte(8'h02, d); xbyte(8'h00, d); xbyte(8'h00, d); xbyte(8'h77, d);
    bitx(1'b0, d[0]); close_f();
    rdsr(q); chk("R6 rise after extra bit starts no cycle", q, 8'h02);
    rd(16'h0000, q); chk("R6 array unchanged", q, 8'hA5);

    // R7: clear latch; set with an extra clock is cancelled
    op(8'h04); rdsr(q); chk("R7 latch cleared", q, 8'h00);
    open_f(); xbyte(8'h06, d); bitx(1'b0, d[0]); close_f();
    rdsr(q); chk("R7 latch set with 9 clocks cancelled", q, 8'h00);

    // R10/R11: busy status, ignored traffic while busy
    op(8'h06); open_f(); xbyte(8'h02, d); xbyte(8'h04, d); xbyte(8'h56, d);
    xbyte(8'h11, d); close_f();
    rdsr(q); chk("R10 status during cycle", q, 8'hFF);
    open_f(); xbyte(8'h02, d); xbyte(8'h00, d); xbyte(8'h00, d); xbyte(8'h99, d); close_f();
    tk(WCLK+100);
    rdsr(q); chk("R10 status after cycle", q, 8'h00);
    rd(16'h0456, q); chk("R10 committed byte", q, 8'h11);
    rd(16'h0000, q); chk("R11 write during busy ignored", q, 8'hA5);

    // R12: block protection
    wrsr(8'h0C); rdsr(q); chk("R12 protect all stored", q, 8'h0C);
    op(8'h06); open_f(); xbyte(8'h02, d); xbyte(8'h00, d); xbyte(8'h00, d);
    xbyte(8'h55, d); close_f(); tk(WCLK+100);
    rdsr(q); chk("R12 protected write leaves latch, no cycle", q, 8'h0E);
    rd(16'h0000, q); chk("R12 protected byte unchanged", q, 8'hA5);
    wrsr(8'h04); rdsr(q); chk("R12 protect top quarter stored", q, 8'h04);
    wr(16'h0200, 8'h66); rd(16'h0200, q); chk("R12 unprotected quarter writable", q, 8'h66);
    wr(16'h07FE, 8'h00); rd(16'h07FE, q); chk("R12 top quarter protected", q, 8'h96);

    // R13: pin lock of status writes
    wrsr(8'hFF); rdsr(q); chk("R13 only bits 7,3,2 kept", q, 8'h8C);
    wp_n = 1'b0; wrsr(8'h00); rdsr(q); chk("R13 locked status write discarded", q, 8'h8E);
    wp_n = 1'b1; wrsr(8'h00); rdsr(q); chk("R13 unlocked status write", q, 8'h00);

    // R9: pause mid-address with stray clocks, then resume
    open_f(); xbyte(8'h03, d); xbyte(8'h02, d);
    for (int i = 0; i < 4; i++) bitx(1'b0, d[0]);
    sck = 1'b0; tk(H); hold_n = 1'b0; tk(H);
    chk("R9 output disabled in hold", {7'b0, so_en}, 8'h00);
    si = 1'b1;
    for (int i = 0; i < 3; i++) begin sck = 1'b1; tk(H); sck = 1'b0; tk(H); end
    hold_n = 1'b1; tk(H);
    chk("R9 output enabled after release", {7'b0, so_en}, 8'h01);
    for (int i = 0; i < 4; i++) bitx(1'b0, d[0]);
    xbyte(8'h00, q); close_f();
    chk("R9 data after resumed address", q, 8'h66);

    summary();
    $finish;
  end
endmodule